// File: doc/BRIEF.md
# Fully Associative Page Translation Cache with Selective Fencing

This block caches recent virtual-to-physical page translations for a load/store pipeline. It holds a small set of entries. Each entry carries a two-level virtual page number, an address-space identifier, a global flag, a superpage flag, a physical page number and permission bits. A lookup presents a virtual address and the current address-space identifier. One cycle later the block answers with a hit flag, the physical address and the permissions. On a miss, an external page-table walker supplies the missing translation through a refill port. Each refill goes to the next slot in round-robin order.

A fence port removes stale translations in a single cycle. Two qualifiers select its scope: whether a virtual address is supplied, and whether an identifier is supplied. Together they give four modes. A global translation is stored once and serves every address space. Identifier-qualified fences never remove it. A fence whose supplied address is not canonical does nothing.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, and a lookup misses.
- R2: A lookup issued in cycle t answers in cycle t+1 with `rsp_valid` high. On a hit against a 4 KiB entry, `rsp_paddr` = {ppn, va[11:0]} and `rsp_perm` returns the stored permission bits. On a miss, `rsp_hit` is low.
- R3: A superpage entry matches when va[31:22] equals its upper page field, whatever va[21:12] holds. Its physical address is {ppn[21:10], va[21:12], va[11:0]}.
- R4: A non-global entry matches only when the low 9 bits of the lookup identifier equal its own. Identifier bits 15:9 are ignored everywhere. A global entry matches under any identifier.
- R5: Refills fill slots 0,1,…,7 and then wrap to 0. The ninth refill therefore evicts the first translation.
- R6: A fence with neither qualifier (`fence_addr_given`=0, `fence_asid_given`=0) empties every slot, global ones included.
- R7: A fence with only the identifier qualifier removes the non-global entries whose identifier matches. Global entries stay.
- R8: A fence with only the address qualifier removes the entries that translate that address, in every address space, global ones included. A superpage matches on va[31:22] alone.
- R9: A fence with both qualifiers removes the non-global entries that translate that address and carry that identifier.
- R10: An address-qualified fence whose address bits 35:31 are not all equal has no effect.
- R11: When a fence and a refill share a cycle, the fence acts first and the refilled slot then holds the new valid entry, even if the fence would match it.
- R12: A lookup in the same cycle as a fence or refill answers from the contents held before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Lookup virtual address |
| req_asid | input | 16 | Current address-space identifier |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 34 | Translated physical address |
| rsp_perm | output | 4 | Permission bits of the hit entry |
| fence_valid | input | 1 | Fence request |
| fence_addr_given | input | 1 | Fence is limited to one virtual address |
| fence_vpage | input | 24 | Fence virtual address bits 35:12 |
| fence_asid_given | input | 1 | Fence is limited to one address space |
| fence_asid | input | 16 | Fence address-space identifier |
| fill_valid | input | 1 | Refill write |
| fill_vpn | input | 20 | Refill virtual page number (va[31:12]) |
| fill_asid | input | 16 | Refill address-space identifier |
| fill_global | input | 1 | Refill entry is global |
| fill_super | input | 1 | Refill entry is a 4 MiB superpage |
| fill_ppn | input | 22 | Refill physical page number |
| fill_perm | input | 4 | Refill permission bits |

## Verification
Fencing and refilling can fall in the same cycle, and a lookup can ride along with both. The bench provokes this by issuing a full flush together with a refill and a lookup of a resident entry. It also issues an address-qualified fence that names the very page being refilled. The result is judged in two ways: the concurrent lookup must still hit with the old translation, and the sweep that follows must find only the newly refilled entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // fence scope, encoded as {address qualifier, identifier qualifier}
   typedef enum logic [1:0] {
      FM_ALL       = 2'b00,
      FM_BY_ASID   = 2'b01,
      FM_BY_ADDR   = 2'b10,
      FM_ADDR_ASID = 2'b11
   } fence_mode_e;
endpackage

// File: rtl/xlat_fence_dec.sv
module xlat_fence_dec #(
   parameter int VP_W  = 24,   // width of the supplied virtual page field
   parameter int VPN_W = 20    // implemented virtual page number width
) (
   input  logic                     fence_valid,
   input  logic                     addr_given,
   input  logic                     asid_given,
   input  logic [VP_W-1:0]          vpage,
   output logic                     fire,
   output xlat_pkg::fence_mode_e    mode
);
   logic canon;

   generate
      if (VP_W > VPN_W) begin : g_ext
         logic [VP_W-VPN_W:0] upper;
         assign upper = vpage[VP_W-1:VPN_W-1];
         assign canon = (&upper) | ~(|upper);
      end else begin : g_flat
         assign canon = 1'b1;
      end
   endgenerate

   assign fire = fence_valid & (~addr_given | canon);
   assign mode = xlat_pkg::fence_mode_e'({addr_given, asid_given});
endmodule

// File: rtl/xlat_rr.sv
module xlat_rr #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n)          ptr <= '0;
      else if (adv) begin
         if (ptr == IDX_W'(N-1)) ptr <= '0;
         else                    ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/xlat_slot.sv
module xlat_slot #(
   parameter int LVL_W  = 10,
   parameter int ASID_W = 9,
   parameter int PPN_W  = 22,
   parameter int PERM_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   // refill
   input  logic                  wr_en,
   input  logic [LVL_W-1:0]      wr_hi,
   input  logic [LVL_W-1:0]      wr_lo,
   input  logic [ASID_W-1:0]     wr_asid,
   input  logic                  wr_glob,
   input  logic                  wr_super,
   input  logic [PPN_W-1:0]      wr_ppn,
   input  logic [PERM_W-1:0]     wr_perm,
   // lookup
   input  logic [LVL_W-1:0]      lk_hi,
   input  logic [LVL_W-1:0]      lk_lo,
   input  logic [ASID_W-1:0]     lk_asid,
   output logic                  lk_match,
   // fence
   input  logic                  fc_fire,
   input  xlat_pkg::fence_mode_e fc_mode,
   input  logic [LVL_W-1:0]      fc_hi,
   input  logic [LVL_W-1:0]      fc_lo,
   input  logic [ASID_W-1:0]     fc_asid,
   // stored contents
   output logic                  vld,
   output logic                  super_pg,
   output logic [PPN_W-1:0]      ppn,
   output logic [PERM_W-1:0]     perm
);
   logic [LVL_W-1:0]  hi_q, lo_q;
   logic [ASID_W-1:0] asid_q;
   logic              glob_q;
   logic              fc_addr_eq, fc_asid_eq, kill;

   assign lk_match = vld & (hi_q == lk_hi) & (super_pg | (lo_q == lk_lo))
                   & (glob_q | (asid_q == lk_asid));

   assign fc_addr_eq = (hi_q == fc_hi) & (super_pg | (lo_q == fc_lo));
   assign fc_asid_eq = ~glob_q & (asid_q == fc_asid);

   always_comb begin
      unique case (fc_mode)
         xlat_pkg::FM_ALL:       kill = 1'b1;
         xlat_pkg::FM_BY_ASID:   kill = fc_asid_eq;
         xlat_pkg::FM_BY_ADDR:   kill = fc_addr_eq;
         xlat_pkg::FM_ADDR_ASID: kill = fc_addr_eq & fc_asid_eq;
         default:                kill = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld      <= 1'b0;
         hi_q     <= '0;
         lo_q     <= '0;
         asid_q   <= '0;
         glob_q   <= 1'b0;
         super_pg <= 1'b0;
         ppn      <= '0;
         perm     <= '0;
      end else if (wr_en) begin
         // a refill overrides a same-cycle fence on this slot
         vld      <= 1'b1;
         hi_q     <= wr_hi;
         lo_q     <= wr_lo;
         asid_q   <= wr_asid;
         glob_q   <= wr_glob;
         super_pg <= wr_super;
         ppn      <= wr_ppn;
         perm     <= wr_perm;
      end else if (fc_fire && kill) begin
         vld <= 1'b0;
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int N_ENTRIES = 8,
   parameter int XLEN      = 36,
   parameter int VA_W      = 32,
   parameter int PGOFF_W   = 12,
   parameter int ASID_IN_W = 16,
   parameter int ASID_W    = 9,
   parameter int PPN_W     = 22,
   parameter int PERM_W    = 4,
   localparam int VPN_W    = VA_W - PGOFF_W,
   localparam int LVL_W    = VPN_W / 2,
   localparam int VP_W     = XLEN - PGOFF_W,
   localparam int PA_W     = PPN_W + PGOFF_W,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [ASID_IN_W-1:0]  req_asid,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic [PA_W-1:0]       rsp_paddr,
   output logic [PERM_W-1:0]     rsp_perm,
   input  logic                  fence_valid,
   input  logic                  fence_addr_given,
   input  logic [VP_W-1:0]       fence_vpage,
   input  logic                  fence_asid_given,
   input  logic [ASID_IN_W-1:0]  fence_asid,
   input  logic                  fill_valid,
   input  logic [VPN_W-1:0]      fill_vpn,
   input  logic [ASID_IN_W-1:0]  fill_asid,
   input  logic                  fill_global,
   input  logic                  fill_super,
   input  logic [PPN_W-1:0]      fill_ppn,
   input  logic [PERM_W-1:0]     fill_perm
);
   // elaboration-time parameter checks
   generate
      if (N_ENTRIES < 2)             begin : g_chk_n    $error("xlat_cache: N_ENTRIES must be at least 2"); end
      if ((VPN_W % 2) != 0)          begin : g_chk_vpn  $error("xlat_cache: page number must split into two equal levels"); end
      if (PPN_W < LVL_W)             begin : g_chk_ppn  $error("xlat_cache: PPN_W narrower than one level"); end
      if (ASID_W > ASID_IN_W)        begin : g_chk_asid $error("xlat_cache: implemented identifier wider than port"); end
      if (XLEN < VA_W)               begin : g_chk_xlen $error("xlat_cache: XLEN below VA_W"); end
   endgenerate

   // identifier bits above ASID_W never take part in a comparison
   generate
      if (ASID_IN_W > ASID_W) begin : g_asid_trim
         logic unused_asid_hi;
         assign unused_asid_hi = ^{req_asid[ASID_IN_W-1:ASID_W],
                                   fence_asid[ASID_IN_W-1:ASID_W],
                                   fill_asid[ASID_IN_W-1:ASID_W]};
      end
   endgenerate

   logic [LVL_W-1:0] req_hi, req_lo, fc_hi, fc_lo;
   assign req_hi = req_vaddr[VA_W-1 -: LVL_W];
   assign req_lo = req_vaddr[PGOFF_W +: LVL_W];
   assign fc_hi  = fence_vpage[VPN_W-1 -: LVL_W];
   assign fc_lo  = fence_vpage[LVL_W-1:0];

   logic                  fc_fire;
   xlat_pkg::fence_mode_e fc_mode;

   xlat_fence_dec #(.VP_W(VP_W), .VPN_W(VPN_W)) u_dec (
      .fence_valid (fence_valid),
      .addr_given  (fence_addr_given),
      .asid_given  (fence_asid_given),
      .vpage       (fence_vpage),
      .fire        (fc_fire),
      .mode        (fc_mode)
   );

   logic [IDX_W-1:0] rr_ptr;
   xlat_rr #(.N(N_ENTRIES)) u_rr (
      .clk (clk), .rst_n (rst_n), .adv (fill_valid), .ptr (rr_ptr)
   );

   logic [N_ENTRIES-1:0] ent_vld, ent_hit, ent_super;
   logic [PPN_W-1:0]     ent_ppn  [N_ENTRIES];
   logic [PERM_W-1:0]    ent_perm [N_ENTRIES];

   generate
      for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
         xlat_slot #(.LVL_W(LVL_W), .ASID_W(ASID_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (fill_valid && (rr_ptr == IDX_W'(g))),
            .wr_hi    (fill_vpn[VPN_W-1 -: LVL_W]),
            .wr_lo    (fill_vpn[LVL_W-1:0]),
            .wr_asid  (fill_asid[ASID_W-1:0]),
            .wr_glob  (fill_global),
            .wr_super (fill_super),
            .wr_ppn   (fill_ppn),
            .wr_perm  (fill_perm),
            .lk_hi    (req_hi),
            .lk_lo    (req_lo),
            .lk_asid  (req_asid[ASID_W-1:0]),
            .lk_match (ent_hit[g]),
            .fc_fire  (fc_fire),
            .fc_mode  (fc_mode),
            .fc_hi    (fc_hi),
            .fc_lo    (fc_lo),
            .fc_asid  (fence_asid[ASID_W-1:0]),
            .vld      (ent_vld[g]),
            .super_pg (ent_super[g]),
            .ppn      (ent_ppn[g]),
            .perm     (ent_perm[g])
         );
      end
   endgenerate

   // lowest-numbered matching slot wins
   logic [IDX_W-1:0]  sel;
   logic [PA_W-1:0]   pa_d;
   always_comb begin
      sel = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (ent_hit[i]) sel = IDX_W'(i);
      end
      if (ent_super[sel])
         pa_d = {ent_ppn[sel][PPN_W-1:LVL_W], req_lo, req_vaddr[PGOFF_W-1:0]};
      else
         pa_d = {ent_ppn[sel], req_vaddr[PGOFF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_paddr <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid & (|ent_hit);
         rsp_paddr <= (req_valid & (|ent_hit)) ? pa_d : '0;
         rsp_perm  <= (req_valid & (|ent_hit)) ? ent_perm[sel] : '0;
      end
   end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int N       = 8,
   parameter int VP_W    = 24,
   parameter int VPN_W   = 20,
   parameter int PGOFF_W = 12,
   parameter int PA_W    = 34,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [PGOFF_W-1:0] req_off,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic [PA_W-1:0]    rsp_paddr,
   input logic               fence_valid,
   input logic               fence_addr_given,
   input logic               fence_asid_given,
   input logic [VP_W-1:0]    fence_vpage,
   input logic               fill_valid,
   input logic [N-1:0]       ent_vld,
   input logic [IDX_W-1:0]   rr_ptr
);
   logic fc_canon;
   assign fc_canon = (&fence_vpage[VP_W-1:VPN_W-1]) | ~(|fence_vpage[VP_W-1:VPN_W-1]);

   AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ent_vld == '0) && !rsp_valid); // R1
   AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_hit); // R2
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !rsp_hit || (rsp_paddr[PGOFF_W-1:0] == $past(req_off))); // R2
   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> int'(rr_ptr) == ((int'($past(rr_ptr)) + 1) % N)); // R5
   AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fence_valid && !fence_addr_given && !fence_asid_given && !fill_valid |=> ent_vld == '0); // R6
   AST_BAD_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      fence_valid && fence_addr_given && !fc_canon && !fill_valid |=> $stable(ent_vld)); // R10
   AST_FILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> ent_vld[$past(rr_ptr)]); // R11
   AST_FLUSH_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fence_valid && !fence_addr_given && !fence_asid_given && fill_valid |=> $countones(ent_vld) == 1); // R11
endmodule

bind xlat_cache xlat_cache_chk #(
   .N(N_ENTRIES), .VP_W(VP_W), .VPN_W(VPN_W), .PGOFF_W(PGOFF_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_off          (req_vaddr[PGOFF_W-1:0]),
   .rsp_valid        (rsp_valid),
   .rsp_hit          (rsp_hit),
   .rsp_paddr        (rsp_paddr),
   .fence_valid      (fence_valid),
   .fence_addr_given (fence_addr_given),
   .fence_asid_given (fence_asid_given),
   .fence_vpage      (fence_vpage),
   .fill_valid       (fill_valid),
   .ent_vld          (ent_vld),
   .rr_ptr           (rr_ptr)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
   localparam int N = 8;

   typedef struct {
      logic [9:0]  hi, lo;
      logic [15:0] asid;
      logic        g, s;
      logic [21:0] ppn;
      logic [3:0]  perm;
   } ent_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0;
   logic [31:0] req_vaddr = '0;
   logic [15:0] req_asid = '0;
   logic        rsp_valid, rsp_hit;
   logic [33:0] rsp_paddr;
   logic [3:0]  rsp_perm;
   logic        fence_valid = 0, fence_addr_given = 0, fence_asid_given = 0;
   logic [23:0] fence_vpage = '0;
   logic [15:0] fence_asid = '0;
   logic        fill_valid = 0, fill_global = 0, fill_super = 0;
   logic [19:0] fill_vpn = '0;
   logic [15:0] fill_asid = '0;
   logic [21:0] fill_ppn = '0;
   logic [3:0]  fill_perm = '0;

   always #10 clk = ~clk;   // 50 MHz

   xlat_cache uut (.*);

   int   n_chk = 0, n_err = 0;
   bit   done = 0;
   ent_t m_ent [N];
   bit   m_vld [N];
   int   m_ptr = 0;

   function automatic ent_t pat(int k);
      ent_t e;
      e.hi   = 10'(k * 37 + 5);
      e.lo   = 10'(k * 11 + 3);
      e.asid = 16'(k % 3) | ((k % 2 == 1) ? 16'hA600 : 16'h0000);
      e.g    = (k % 5 == 4);
      e.s    = (k % 4 == 2);
      e.ppn  = 22'(k * 4099 + 1);
      e.perm = 4'(k);
      return e;
   endfunction

   function automatic logic [35:0] mkva(logic [9:0] hi, logic [9:0] lo, logic [11:0] off);
      return {{4{hi[9]}}, hi, lo, off};
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic void model_lookup(logic [35:0] va, logic [15:0] asid,
                                        output bit hit, output logic [33:0] pa, output logic [3:0] perm);
      hit = 0; pa = '0; perm = '0;
      for (int i = 0; i < N; i++) begin
         if (!hit && m_vld[i] && m_ent[i].hi == va[31:22] && (m_ent[i].s || m_ent[i].lo == va[21:12])
             && (m_ent[i].g || m_ent[i].asid[8:0] == asid[8:0])) begin
            hit  = 1;
            perm = m_ent[i].perm;
            pa   = m_ent[i].s ? {m_ent[i].ppn[21:10], va[21:0]} : {m_ent[i].ppn, va[11:0]};
         end
      end
   endfunction

   function automatic void model_fence(bit ag, logic [35:0] va, bit sg, logic [15:0] asid);
      if (ag && !(va[35:31] == 5'h1f || va[35:31] == 5'h00)) return;
      for (int i = 0; i < N; i++) begin
         bit a_ok, s_ok;
         a_ok = !ag || (m_ent[i].hi == va[31:22] && (m_ent[i].s || m_ent[i].lo == va[21:12]));
         s_ok = !sg || (!m_ent[i].g && m_ent[i].asid[8:0] == asid[8:0]);
         if (a_ok && s_ok) m_vld[i] = 0;
      end
   endfunction

   // one cycle with any combination of fence, refill and lookup
   task automatic cyc(bit f_en, bit ag, logic [35:0] fva, bit sg, logic [15:0] fas,
                      bit w_en, ent_t w, bit l_en, logic [35:0] lva, logic [15:0] las, string req);
      bit e_hit; logic [33:0] e_pa; logic [3:0] e_perm;
      @(negedge clk);
      fence_valid = f_en; fence_addr_given = ag; fence_vpage = fva[35:12];
      fence_asid_given = sg; fence_asid = fas;
      fill_valid = w_en; fill_vpn = {w.hi, w.lo}; fill_asid = w.asid;
      fill_global = w.g; fill_super = w.s; fill_ppn = w.ppn; fill_perm = w.perm;
      req_valid = l_en; req_vaddr = lva[31:0]; req_asid = las;
      model_lookup(lva, las, e_hit, e_pa, e_perm);
      @(negedge clk);
      fence_valid = 0; fill_valid = 0; req_valid = 0;
      if (f_en) model_fence(ag, fva, sg, fas);
      if (w_en) begin
         m_ent[m_ptr] = w; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % N;
      end
      if (l_en) begin
         chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
         chk(req, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
         if (e_hit) begin
            chk(req, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
            chk(req, "rsp_perm", 64'(rsp_perm), 64'(e_perm));
         end
      end
   endtask

   task automatic fill(int k);
      cyc(0, 0, '0, 0, '0, 1, pat(k), 0, '0, '0, "R5");
   endtask

   task automatic look(logic [35:0] va, logic [15:0] asid, string req);
      cyc(0, 0, '0, 0, '0, 0, pat(0), 1, va, asid, req);
   endtask

   // lookups of patterns base..base+N-1 under several identifiers and offsets
   task automatic sweep(int base, string req);
      for (int k = base; k < base + N; k++) begin
         ent_t e = pat(k);
         for (int a = 0; a < 4; a++) begin
            logic [15:0] las = 16'(a) | ((a % 2 == 1) ? 16'h5200 : 16'h0000);
            look(mkva(e.hi, e.lo, 12'(k * 291 + a)), las, req);
            look(mkva(e.hi, e.lo ^ 10'h155, 12'(a * 7)), las, req);
         end
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      string fm [4];
      fm[0] = "R6"; fm[1] = "R7"; fm[2] = "R8"; fm[3] = "R9";
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_ent[i] = pat(0); end
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      sweep(0, "R1");

      // fill all slots and sweep translations, superpages, identifiers
      for (int k = 0; k < N; k++) fill(k);
      sweep(0, "R2/R3/R4");

      // ninth refill evicts slot 0
      fill(N);
      look(mkva(pat(0).hi, pat(0).lo, 12'h0), pat(0).asid, "R5");
      look(mkva(pat(N).hi, pat(N).lo, 12'h0), pat(N).asid, "R5");
      sweep(1, "R5");

      // every fence mode against every resident target
      for (int md = 0; md < 4; md++) begin
         for (int t = 0; t < N; t++) begin
            ent_t e;
            for (int k = 16; k < 16 + N; k++) fill(k);
            e = pat(16 + t);
            cyc(1, md[1], mkva(e.hi, (t % 2 == 1) ? e.lo ^ 10'h2a : e.lo, 12'h0),
                md[0], e.asid ^ 16'h0400, 0, pat(0), 0, '0, '0, fm[md]);
            sweep(16, fm[md]);
         end
      end

      // non-canonical fence address: nothing removed
      for (int k = 24; k < 24 + N; k++) fill(k);
      for (int sg = 0; sg < 2; sg++) begin
         ent_t e = pat(24 + 2 * sg);
         cyc(1, 1, {4'b0101, e.hi, e.lo, 12'h0}, sg[0], e.asid, 0, pat(0), 0, '0, '0, "R10");
         sweep(24, "R10");
      end

      // full flush, refill and lookup in one cycle
      cyc(1, 0, '0, 0, '0, 1, pat(40), 1,
          mkva(pat(25).hi, pat(25).lo, 12'h5a5), pat(25).asid, "R12");
      sweep(36, "R11");
      sweep(24, "R11");

      // address fence naming the page being refilled
      cyc(1, 1, mkva(pat(41).hi, pat(41).lo, 12'h0), 0, '0, 1, pat(41), 1,
          mkva(pat(40).hi, pat(40).lo, 12'h010), pat(40).asid, "R12");
      sweep(40, "R11");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule